// File: doc/BRIEF.md
# Read-Ahead Segment Hit Classifier

This block guards one segment of a circular sector buffer used for read-ahead. It remembers which run of logical block addresses the segment holds: a start address, a count of sectors already present and the buffer slot of the first one. It also remembers the last address of the previous read. For every read request it decides whether the data is absent, continues the previous read, is fully present or is partly present. From that decision it produces two buffer slot pointers. The host pointer tells the host transfer engine where to start reading out. The disk pointer tells the media engine where the next sector from the platter must land.

The media engine reports each sector it writes into the segment with a one-cycle fill pulse. This lets the segment keep growing past the requested range after a read has been served. A write request whose address range touches the held range makes the segment empty. The result of a read appears one clock after the request strobe, together with a one-cycle done pulse. Pointer arithmetic wraps at the segment size, which must be a power of two.

Top module: `rahc_top`

## Requirements
- R1: After reset, done is 0, hit_class is 0 and both pointers are 0. The segment is empty with its base at slot 0, so the first read is a miss at slot 0.
- R2: done is 1 in exactly the cycle after a read strobe (req_valid=1, req_write=0) and 0 otherwise. A write strobe never raises done. hit_class and both pointers change only with done.
- R3: A miss reports hit_class 0 (MISS). The new segment starts at the requested address with zero sectors, at slot (old base + old count) mod SEG. host_ptr and disk_ptr both equal that slot.
- R4: Each fill pulse adds one sector to the segment, saturating at SEG sectors.
- R5: With offset = request start minus segment start: if offset < count and offset + request count <= count, the read is a full hit, hit_class 2. host_ptr = (base + offset) mod SEG and disk_ptr = (base + count) mod SEG.
- R6: If offset < count but offset + request count > count, the read is a partial hit, hit_class 3. host_ptr points at the cached part and disk_ptr just past it, using the same formulas as R5.
- R7: If a read history is valid and the request starts at the previous read's last address + 1 (and not below the segment start), the read is a sequential hit, hit_class 1. It uses the R5 pointer formulas and takes priority over full and partial hit.
- R8: A request whose start is below the segment start is always a miss.
- R9: A write whose range overlaps the held sectors empties the segment and clears the read history, so the next read is a miss. A write outside that range changes nothing.
- R10: When a fill pulse coincides with a read, classification uses the count before the pulse. The pulse is kept on a hit and dropped on a miss. When a fill pulse coincides with an overlapping write, the write wins and the count becomes 0.
- R11: Both pointers wrap modulo SEG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per command |
| req_write | input | 1 | 1 = write command, 0 = read command |
| req_lba | input | LBA_W | First logical block address of the command |
| req_count | input | CNT_W | Sector count of the command, nonzero |
| fill_tick | input | 1 | One sector written into the segment by the media engine |
| done | output | 1 | Result valid pulse, one cycle after a read strobe |
| hit_class | output | 2 | 0 miss, 1 sequential, 2 full hit, 3 partial hit |
| host_ptr | output | log2(SEG_SECTORS) | Buffer slot where host transfer starts |
| disk_ptr | output | log2(SEG_SECTORS) | Buffer slot where the next media sector lands |

## Verification
Two things can fall in the same cycle: a fill pulse from the media side, and a command strobe that either reclassifies the segment or invalidates it. The bench drives a fill pulse in the same cycle as a sequential read, as a missing read and as an overlapping write. It then issues a follow-up read whose class and disk pointer differ depending on whether that pulse was counted. A count that was kept, dropped or overridden wrongly shows up as a full hit where a miss was expected, or as a disk pointer off by one.

// File: rtl/rahc_pkg.sv
// Shared types for the read-ahead segment hit classifier.
package rahc_pkg;
    // Classification codes; the encoding is visible on the hit_class port.
    typedef enum logic [1:0] {
        CLS_MISS = 2'd0,
        CLS_SEQ  = 2'd1,
        CLS_FULL = 2'd2,
        CLS_PART = 2'd3
    } hit_class_e;
endpackage

// File: rtl/rahc_range_tracker.sv
// Holds the segment state: start address, present-sector count, base slot,
// and the last address of the previous read. Assumes SEG_SECTORS is a power
// of two, one command per strobe, and a nonzero command count.
module rahc_range_tracker #(
    parameter int LBA_W       = 28,
    parameter int CNT_W       = 8,
    parameter int SEG_SECTORS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_take,
    input  logic                          rd_miss,
    input  logic                          wr_take,
    input  logic [LBA_W-1:0]              rq_lba,
    input  logic [CNT_W-1:0]              rq_cnt,
    input  logic                          fill_tick,
    output logic [LBA_W-1:0]              seg_lba,
    output logic [$clog2(SEG_SECTORS):0]  seg_cnt,
    output logic [$clog2(SEG_SECTORS)-1:0] seg_base,
    output logic                          hist_valid,
    output logic [LBA_W-1:0]              hist_end
);
    localparam int PTR_W = $clog2(SEG_SECTORS);
    localparam int OCC_W = PTR_W + 1;
    localparam int SUM_W = LBA_W + 1;

    logic [SUM_W-1:0] rq_last;
    logic [SUM_W-1:0] seg_last;
    logic             overlap;
    logic             room;
    logic [PTR_W-1:0] next_base;

    // Inclusive end addresses of the command and of the held range.
    always_comb begin
        rq_last  = {1'b0, rq_lba} + SUM_W'(rq_cnt) - SUM_W'(1);
        seg_last = {1'b0, seg_lba} + SUM_W'(seg_cnt) - SUM_W'(1);
    end

    // Write overlap test, fill headroom and slot of a fresh segment.
    always_comb begin
        overlap   = wr_take && (seg_cnt != '0)
                    && ({1'b0, rq_lba} <= seg_last)
                    && (rq_last >= {1'b0, seg_lba});
        room      = seg_cnt < OCC_W'(SEG_SECTORS);
        next_base = seg_base + seg_cnt[PTR_W-1:0];
    end

    // Segment range update: miss restarts, overlap empties, fill grows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_lba  <= '0;
            seg_cnt  <= '0;
            seg_base <= '0;
        end else if (rd_take && rd_miss) begin
            seg_lba  <= rq_lba;
            seg_cnt  <= '0;
            seg_base <= next_base;
        end else if (overlap) begin
            seg_cnt  <= '0;
        end else if (fill_tick && room) begin
            seg_cnt  <= seg_cnt + OCC_W'(1);
        end
    end

    // Previous-read history for sequential detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_valid <= 1'b0;
            hist_end   <= '0;
        end else if (rd_take) begin
            hist_valid <= 1'b1;
            hist_end   <= rq_last[LBA_W-1:0];
        end else if (overlap) begin
            hist_valid <= 1'b0;
        end
    end

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_cnt <= OCC_W'(SEG_SECTORS));

    // R4
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_cnt != $past(seg_cnt)) |->
            ((seg_cnt == $past(seg_cnt) + OCC_W'(1)) || (seg_cnt == '0)));
endmodule

// File: rtl/rahc_classifier.sv
// Combinational decision: compares a read against the segment and history
// and yields the class plus host and disk slots. Assumes SEG_SECTORS is a
// power of two so slot sums wrap by truncation.
module rahc_classifier
    import rahc_pkg::*;
#(
    parameter int LBA_W       = 28,
    parameter int CNT_W       = 8,
    parameter int SEG_SECTORS = 64
) (
    input  logic [LBA_W-1:0]               rq_lba,
    input  logic [CNT_W-1:0]               rq_cnt,
    input  logic [LBA_W-1:0]               seg_lba,
    input  logic [$clog2(SEG_SECTORS):0]   seg_cnt,
    input  logic [$clog2(SEG_SECTORS)-1:0] seg_base,
    input  logic                           hist_valid,
    input  logic [LBA_W-1:0]               hist_end,
    output hit_class_e                     cls,
    output logic                           is_miss,
    output logic [$clog2(SEG_SECTORS)-1:0] hap,
    output logic [$clog2(SEG_SECTORS)-1:0] dap
);
    localparam int PTR_W = $clog2(SEG_SECTORS);
    localparam int SUM_W = LBA_W + 1;

    logic             below;
    logic [LBA_W-1:0] offset;
    logic [SUM_W-1:0] tail;
    logic             in_range;
    logic             fits;
    logic             follows;
    logic [PTR_W-1:0] fresh_slot;

    // Position of the request relative to the segment.
    always_comb begin
        below    = rq_lba < seg_lba;
        offset   = rq_lba - seg_lba;
        tail     = {1'b0, offset} + SUM_W'(rq_cnt);
        in_range = !below && (offset < LBA_W'(seg_cnt));
        fits     = tail <= SUM_W'(seg_cnt);
        follows  = hist_valid && !below
                   && ({1'b0, rq_lba} == {1'b0, hist_end} + SUM_W'(1));
    end

    // Priority decision: below start, sequential, full, partial, miss.
    always_comb begin
        if (below)               cls = CLS_MISS;
        else if (follows)        cls = CLS_SEQ;
        else if (in_range && fits) cls = CLS_FULL;
        else if (in_range)       cls = CLS_PART;
        else                     cls = CLS_MISS;
        is_miss = (cls == CLS_MISS);
    end

    // Slot pointers; the slot after the last present sector is shared.
    always_comb begin
        fresh_slot = seg_base + seg_cnt[PTR_W-1:0];
        hap        = is_miss ? fresh_slot : seg_base + offset[PTR_W-1:0];
        dap        = fresh_slot;
    end
endmodule

// File: rtl/rahc_result_reg.sv
// Output stage: captures class and pointers on a read strobe and pulses
// done for one cycle. Holds the last result between reads.
module rahc_result_reg
    import rahc_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_take,
    input  hit_class_e       cls_in,
    input  logic [PTR_W-1:0] hap_in,
    input  logic [PTR_W-1:0] dap_in,
    output logic             done,
    output logic [1:0]       cls_q,
    output logic [PTR_W-1:0] hap_q,
    output logic [PTR_W-1:0] dap_q
);
    // Result capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            cls_q <= 2'd0;
            hap_q <= '0;
            dap_q <= '0;
        end else begin
            done <= rd_take;
            if (rd_take) begin
                cls_q <= cls_in;
                hap_q <= hap_in;
                dap_q <= dap_in;
            end
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_take) |-> ($stable(hap_q) && $stable(dap_q) && $stable(cls_q)));

    // R3
    miss_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_q == 2'd0) |-> (hap_q == dap_q));
endmodule

// File: rtl/rahc_top.sv
// Read-ahead segment hit classifier top. Splits the command strobe into
// read and write, feeds the classifier from the tracked segment state and
// registers the result. Assumes one command per strobe with nonzero count.
module rahc_top
    import rahc_pkg::*;
#(
    parameter int LBA_W       = 28,
    parameter int CNT_W       = 8,
    parameter int SEG_SECTORS = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [LBA_W-1:0]               req_lba,
    input  logic [CNT_W-1:0]               req_count,
    input  logic                           fill_tick,
    output logic                           done,
    output logic [1:0]                     hit_class,
    output logic [$clog2(SEG_SECTORS)-1:0] host_ptr,
    output logic [$clog2(SEG_SECTORS)-1:0] disk_ptr
);
    localparam int PTR_W = $clog2(SEG_SECTORS);
    localparam int OCC_W = PTR_W + 1;

    logic             rd_take;
    logic             wr_take;
    logic [LBA_W-1:0] seg_lba;
    logic [OCC_W-1:0] seg_cnt;
    logic [PTR_W-1:0] seg_base;
    logic             hist_valid;
    logic [LBA_W-1:0] hist_end;
    hit_class_e       cls;
    logic             is_miss;
    logic [PTR_W-1:0] hap;
    logic [PTR_W-1:0] dap;

    // Command strobe split by direction.
    always_comb begin
        rd_take = req_valid && !req_write;
        wr_take = req_valid && req_write;
    end

    rahc_range_tracker #(
        .LBA_W(LBA_W), .CNT_W(CNT_W), .SEG_SECTORS(SEG_SECTORS)
    ) i_tracker (
        .clk(clk), .rst_n(rst_n),
        .rd_take(rd_take), .rd_miss(is_miss), .wr_take(wr_take),
        .rq_lba(req_lba), .rq_cnt(req_count), .fill_tick(fill_tick),
        .seg_lba(seg_lba), .seg_cnt(seg_cnt), .seg_base(seg_base),
        .hist_valid(hist_valid), .hist_end(hist_end)
    );

    rahc_classifier #(
        .LBA_W(LBA_W), .CNT_W(CNT_W), .SEG_SECTORS(SEG_SECTORS)
    ) i_classifier (
        .rq_lba(req_lba), .rq_cnt(req_count),
        .seg_lba(seg_lba), .seg_cnt(seg_cnt), .seg_base(seg_base),
        .hist_valid(hist_valid), .hist_end(hist_end),
        .cls(cls), .is_miss(is_miss), .hap(hap), .dap(dap)
    );

    rahc_result_reg #(
        .PTR_W(PTR_W)
    ) i_result (
        .clk(clk), .rst_n(rst_n), .rd_take(rd_take),
        .cls_in(cls), .hap_in(hap), .dap_in(dap),
        .done(done), .cls_q(hit_class), .hap_q(host_ptr), .dap_q(disk_ptr)
    );

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && !req_write));

    // R2
    done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write) |-> done);
endmodule

// File: tb/test_rahc_top.sv
// Directed bench for the read-ahead segment hit classifier (SEG = 16).
module test_rahc_top;
    localparam int CLK_PERIOD = 10;
    localparam int LBA_W = 16;
    localparam int CNT_W = 8;
    localparam int SEG   = 16;
    localparam int PTR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [LBA_W-1:0] req_lba = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             fill_tick = 1'b0;
    logic             done;
    logic [1:0]       hit_class;
    logic [PTR_W-1:0] host_ptr;
    logic [PTR_W-1:0] disk_ptr;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rahc_top #(.LBA_W(LBA_W), .CNT_W(CNT_W), .SEG_SECTORS(SEG)) i_rahc_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lba(req_lba), .req_count(req_count), .fill_tick(fill_tick),
        .done(done), .hit_class(hit_class), .host_ptr(host_ptr), .disk_ptr(disk_ptr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) fill_tick = 1'b1;
        end
        @(negedge clk) fill_tick = 1'b0;
    endtask

    // Issues one read, checks the result one clock later and the done fall.
    task automatic do_read(input int lba, input int cnt, input bit tick,
                           input int e_cls, input int e_hap, input int e_dap,
                           input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_lba = LBA_W'(lba); req_count = CNT_W'(cnt); fill_tick = tick;
        @(negedge clk);
        req_valid = 1'b0; fill_tick = 1'b0;
        check(req, "done", int'(done), 1);
        check(req, "class", int'(hit_class), e_cls);
        check(req, "host_ptr", int'(host_ptr), e_hap);
        check(req, "disk_ptr", int'(disk_ptr), e_dap);
        @(negedge clk);
        check("R2", "done fall", int'(done), 0);
    endtask

    // Issues one write; done must stay low.
    task automatic do_write(input int lba, input int cnt, input bit tick);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_lba = LBA_W'(lba); req_count = CNT_W'(cnt); fill_tick = tick;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; fill_tick = 1'b0;
        check("R2", "done after write", int'(done), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done", int'(done), 0);
        check("R1", "class", int'(hit_class), 0);
        check("R1", "host_ptr", int'(host_ptr), 0);
        check("R1", "disk_ptr", int'(disk_ptr), 0);
        do_read(100, 4, 1'b0, 0, 0, 0, "R1");
    endtask

    task automatic t_hits();
        do_fill(6);                              // segment 100..105 in slots 0..5
        do_read(101, 3, 1'b0, 2, 1, 6, "R5");
        do_read(104, 4, 1'b0, 1, 4, 6, "R7");    // would be partial without priority
        do_read(103, 5, 1'b0, 3, 3, 6, "R6");
    endtask

    task automatic t_saturate();
        do_fill(20);                             // capped at 16 sectors
        do_read(100, 17, 1'b0, 3, 0, 0, "R4");   // DAP wraps to 0 (R11)
        do_read(99, 1, 1'b0, 0, 0, 0, "R8");
    endtask

    task automatic t_wrap();
        do_fill(5);
        do_read(200, 2, 1'b0, 0, 5, 5, "R3");
        do_fill(13);
        do_read(210, 3, 1'b0, 2, 15, 2, "R11");
        do_read(211, 2, 1'b0, 2, 0, 2, "R11");
    endtask

    task automatic t_same_cycle();
        do_read(213, 2, 1'b1, 1, 2, 2, "R10");   // tick kept after sequential
        do_read(200, 14, 1'b0, 2, 5, 3, "R10");
        do_read(500, 1, 1'b1, 0, 3, 3, "R10");   // tick dropped on miss
        do_read(500, 1, 1'b0, 0, 3, 3, "R10");
    endtask

    task automatic t_writes();
        do_fill(4);                              // segment 500..503
        do_write(504, 2, 1'b0);
        do_read(502, 2, 1'b0, 2, 5, 7, "R9");    // untouched by outside write
        do_write(498, 3, 1'b0);
        do_read(504, 1, 1'b0, 0, 3, 3, "R9");    // would be sequential if kept
        do_fill(2);
        do_write(505, 1, 1'b1);                  // invalidate beats fill
        do_read(504, 1, 1'b0, 0, 3, 3, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_hits();
        t_saturate();
        t_wrap();
        t_same_cycle();
        t_writes();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule